// File: doc/BRIEF.md
# Packed BCD Decimal Adjust Unit

This unit corrects the low accumulator byte of a small 16-bit CPU datapath after a binary addition or subtraction of two packed decimal operands, so that the byte again holds two valid decimal digits. It also performs the word-to-doubleword sign extension of the accumulator. The operation select picks one of three functions. The incoming auxiliary-carry and carry flags from the preceding arithmetic drive the correction.

The correction runs in two steps. The low step adjusts by 06h when the low nibble is out of decimal range or the auxiliary carry is set. The high step adjusts by 60h. It tests the byte after the low step, not the original byte, and is forced by the incoming carry. Along with the new byte the unit produces the carry, auxiliary-carry, sign, zero and parity flags. A 9-bit write mask tells the surrounding flag register which flags to update. A separate indication marks the overflow flag as undefined.

Each operation is accepted through a valid/ready handshake and its result is registered. The result is held at the output until the consumer takes it.

Top module: `bcd_adjust_unit`

## Requirements
- R1: In add-adjust (op 0) and subtract-adjust (op 1), when the low nibble of the input byte exceeds 9 or af_i is 1, the byte is changed by 06h (added for op 0, subtracted for op 1) and af_o is 1; otherwise the byte is unchanged by this step and af_o is 0.
- R2: After the low step, when the intermediate byte exceeds 9Fh or cf_i is 1, 60h is added to the byte (op 0) and cf_o is 1; otherwise cf_o is 0. All byte arithmetic wraps modulo 256, and a wrap in the 06h step does not set cf_o.
- R3: Subtract-adjust (op 1) uses the same two tests as R1 and R2, subtracts 06h and 60h instead of adding them, and sets af_o and cf_o under the same conditions.
- R4: pf_o is 1 when the output byte has an even number of set bits. sf_o equals bit 7 of the output byte. zf_o is 1 when the output byte is 00h.
- R5: flag_we_o uses bit 0 for CF, bit 1 for PF, bit 2 for AF, bit 3 for ZF, bit 4 for SF, bit 5 for TF, bit 6 for IF, bit 7 for DF and bit 8 for OF. Both adjust ops give flag_we_o = 01Fh and of_undef_o = 1.
- R6: Sign extend (op 2) gives ext_o = 0000h when word_i < 8000h and FFFFh otherwise. It gives flag_we_o = 0 and of_undef_o = 0.
- R7: Op 3 is reserved. It writes no flag (flag_we_o = 0, of_undef_o = 0), passes byte_i unchanged to byte_o and gives ext_o = 0000h.
- R8: in_ready_o is 1 when out_valid_o is 0 or out_ready_i is 1. An operation accepted on a clock edge appears at the outputs with out_valid_o = 1 after that edge. While out_valid_o is 1 and out_ready_i is 0, all outputs stay unchanged. When out_ready_i is 1 and nothing new is accepted, out_valid_o goes to 0.
- R9: While rst_ni is low, out_valid_o is 0, in_ready_o is 1 and byte_o is 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation offered |
| in_ready_o | output | 1 | Unit can take an operation |
| op_i | input | 2 | 0 add-adjust, 1 subtract-adjust, 2 sign extend, 3 reserved |
| byte_i | input | 8 | Low accumulator byte |
| word_i | input | 16 | Accumulator word |
| af_i | input | 1 | Incoming auxiliary carry |
| cf_i | input | 1 | Incoming carry |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Consumer takes the result |
| byte_o | output | 8 | Corrected byte |
| ext_o | output | 16 | High extension word |
| cf_o | output | 1 | New carry |
| af_o | output | 1 | New auxiliary carry |
| sf_o | output | 1 | New sign |
| zf_o | output | 1 | New zero |
| pf_o | output | 1 | New parity |
| flag_we_o | output | 9 | Per-flag write mask |
| of_undef_o | output | 1 | Overflow flag left undefined |

## Verification
The adjust modes are driven with bytes that need no correction, only the low correction, only the high correction, or both. This separates each step's enable from the other. Some inputs enter the high range only through the low step, such as 9Ah on add and 05h with the auxiliary carry on subtract. These show whether the high test uses the intermediate byte. Other inputs wrap past zero in the 06h step without setting the carry. Flag-only forcing, with the incoming carry or auxiliary carry set on an in-range byte, confirms the flags drive the correction on their own. Sign extension is tried just below and at the sign boundary, and a stalled consumer shows that the held result does not change under new offers.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;

  typedef enum logic [1:0] {
    OP_ADD_ADJ = 2'd0,
    OP_SUB_ADJ = 2'd1,
    OP_SEXT    = 2'd2,
    OP_RSVD    = 2'd3
  } adj_op_e;

  localparam int NUM_FLAGS = 9;
  localparam int FLG_CF = 0;
  localparam int FLG_PF = 1;
  localparam int FLG_AF = 2;
  localparam int FLG_ZF = 3;
  localparam int FLG_SF = 4;
  localparam int FLG_TF = 5;
  localparam int FLG_IF = 6;
  localparam int FLG_DF = 7;
  localparam int FLG_OF = 8;

  localparam logic [NUM_FLAGS-1:0] ADJ_WE =
      NUM_FLAGS'((1 << FLG_CF) | (1 << FLG_PF) | (1 << FLG_AF) |
                 (1 << FLG_ZF) | (1 << FLG_SF));

endpackage

// File: rtl/bcd_fix_step.sv
// One correction step: a range test plus a conditional add or subtract of a constant.
module bcd_fix_step #(
  parameter int DATA_W   = 8,
  parameter int LIMIT    = 9,
  parameter int FIX      = 6,
  parameter bit NIB_TEST = 1'b1
) (
  input  logic [DATA_W-1:0] val_i,
  input  logic              sub_i,
  input  logic              force_i,
  output logic [DATA_W-1:0] val_o,
  output logic              hit_o
);
  localparam int NIB_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] FIX_V = DATA_W'(FIX);

  logic over;

  generate
    if (NIB_TEST) begin : g_nib
      assign over = (val_i[NIB_W-1:0] > NIB_W'(LIMIT));
    end else begin : g_full
      assign over = (val_i > DATA_W'(LIMIT));
    end
  endgenerate

  assign hit_o = force_i | over;

  always_comb begin
    if (!hit_o)     val_o = val_i;
    else if (sub_i) val_o = val_i - FIX_V;
    else            val_o = val_i + FIX_V;
  end
endmodule

// File: rtl/bcd_flag_gen.sv
module bcd_flag_gen #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] val_i,
  output logic              sf_o,
  output logic              zf_o,
  output logic              pf_o
);
  assign sf_o = val_i[DATA_W-1];
  assign zf_o = (val_i == '0);
  assign pf_o = ~^val_i;
endmodule

// File: rtl/bcd_adj_core.sv
module bcd_adj_core
  import bcd_adj_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WORD_W = 16
) (
  input  adj_op_e               op_i,
  input  logic [DATA_W-1:0]     byte_i,
  input  logic [WORD_W-1:0]     word_i,
  input  logic                  af_i,
  input  logic                  cf_i,
  output logic [DATA_W-1:0]     byte_o,
  output logic [WORD_W-1:0]     ext_o,
  output logic                  af_o,
  output logic                  cf_o,
  output logic [NUM_FLAGS-1:0]  we_o,
  output logic                  of_undef_o
);
  localparam int NIB_W  = DATA_W / 2;
  localparam int LO_LIM = 9;
  localparam int HI_LIM = (10 << NIB_W) - 1;
  localparam int LO_FIX = 6;
  localparam int HI_FIX = 6 << NIB_W;

  logic              is_adj, is_sub;
  logic [DATA_W-1:0] lo_val, hi_val;
  logic              lo_hit, hi_hit;

  assign is_adj = (op_i == OP_ADD_ADJ) || (op_i == OP_SUB_ADJ);
  assign is_sub = (op_i == OP_SUB_ADJ);

  bcd_fix_step #(.DATA_W(DATA_W), .LIMIT(LO_LIM), .FIX(LO_FIX), .NIB_TEST(1'b1)) u_lo (
    .val_i(byte_i), .sub_i(is_sub), .force_i(af_i), .val_o(lo_val), .hit_o(lo_hit)
  );

  // high test sees the byte after the low step
  bcd_fix_step #(.DATA_W(DATA_W), .LIMIT(HI_LIM), .FIX(HI_FIX), .NIB_TEST(1'b0)) u_hi (
    .val_i(lo_val), .sub_i(is_sub), .force_i(cf_i), .val_o(hi_val), .hit_o(hi_hit)
  );

  assign ext_o = (op_i == OP_SEXT && word_i[WORD_W-1]) ? {WORD_W{1'b1}} : {WORD_W{1'b0}};

  always_comb begin
    if (is_adj) begin
      byte_o     = hi_val;
      af_o       = lo_hit;
      cf_o       = hi_hit;
      we_o       = ADJ_WE;
      of_undef_o = 1'b1;
    end else begin
      byte_o     = byte_i;
      af_o       = 1'b0;
      cf_o       = 1'b0;
      we_o       = '0;
      of_undef_o = 1'b0;
    end
  end
endmodule

// File: rtl/bcd_adjust_unit.sv
module bcd_adjust_unit
  import bcd_adj_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WORD_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [1:0]           op_i,
  input  logic [DATA_W-1:0]    byte_i,
  input  logic [WORD_W-1:0]    word_i,
  input  logic                 af_i,
  input  logic                 cf_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [DATA_W-1:0]    byte_o,
  output logic [WORD_W-1:0]    ext_o,
  output logic                 cf_o,
  output logic                 af_o,
  output logic                 sf_o,
  output logic                 zf_o,
  output logic                 pf_o,
  output logic [NUM_FLAGS-1:0] flag_we_o,
  output logic                 of_undef_o
);
  logic [DATA_W-1:0]    c_byte;
  logic [WORD_W-1:0]    c_ext;
  logic                 c_af, c_cf, c_sf, c_zf, c_pf, c_ofu;
  logic [NUM_FLAGS-1:0] c_we;
  logic                 in_fire;

  bcd_adj_core #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_core (
    .op_i      (adj_op_e'(op_i)),
    .byte_i    (byte_i),
    .word_i    (word_i),
    .af_i      (af_i),
    .cf_i      (cf_i),
    .byte_o    (c_byte),
    .ext_o     (c_ext),
    .af_o      (c_af),
    .cf_o      (c_cf),
    .we_o      (c_we),
    .of_undef_o(c_ofu)
  );

  bcd_flag_gen #(.DATA_W(DATA_W)) u_flags (
    .val_i(c_byte), .sf_o(c_sf), .zf_o(c_zf), .pf_o(c_pf)
  );

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign in_fire    = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      byte_o      <= '0;
      ext_o       <= '0;
      cf_o        <= 1'b0;
      af_o        <= 1'b0;
      sf_o        <= 1'b0;
      zf_o        <= 1'b0;
      pf_o        <= 1'b0;
      flag_we_o   <= '0;
      of_undef_o  <= 1'b0;
    end else begin
      if (in_fire) begin
        byte_o     <= c_byte;
        ext_o      <= c_ext;
        cf_o       <= c_cf;
        af_o       <= c_af;
        sf_o       <= c_sf;
        zf_o       <= c_zf;
        pf_o       <= c_pf;
        flag_we_o  <= c_we;
        of_undef_o <= c_ofu;
      end
      if (in_fire)          out_valid_o <= 1'b1;
      else if (out_ready_i) out_valid_o <= 1'b0;
    end
  end

  // R8
  accept_to_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_fire |=> out_valid_o);

  // R8
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(byte_o) && $stable(ext_o) && $stable(flag_we_o) && $stable(cf_o)));

  // R6
  sext_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_fire && op_i == OP_SEXT) |=> (ext_o == {WORD_W{$past(word_i[WORD_W-1])}}));

  // R2
  add_cf_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_fire && op_i == OP_ADD_ADJ && cf_i) |=> cf_o);

  // R1
  af_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_fire && op_i != OP_SEXT && op_i != OP_RSVD && af_i) |=> af_o);

  // R5
  mask_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ((flag_we_o == ADJ_WE && of_undef_o) || (flag_we_o == '0 && !of_undef_o)));
endmodule

// File: tb/sim_bcd_adjust_unit.sv
`timescale 1ns/1ps
module sim_bcd_adjust_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, out_ready = 1'b1;
  logic        in_ready, out_valid;
  logic [1:0]  op = 2'd0;
  logic [7:0]  byte_in = 8'h00;
  logic [15:0] word_in = 16'h0000;
  logic        af_in = 1'b0, cf_in = 1'b0;
  logic [7:0]  byte_out;
  logic [15:0] ext_out;
  logic        cf_out, af_out, sf_out, zf_out, pf_out, ofu_out;
  logic [8:0]  we_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bcd_adjust_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .op_i(op), .byte_i(byte_in), .word_i(word_in), .af_i(af_in), .cf_i(cf_in),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .byte_o(byte_out),
    .ext_o(ext_out), .cf_o(cf_out), .af_o(af_out), .sf_o(sf_out), .zf_o(zf_out),
    .pf_o(pf_out), .flag_we_o(we_out), .of_undef_o(ofu_out)
  );

  // {op, byte, af, cf, expected byte, expected af, expected cf}
  localparam int NV = 13;
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 8'h12, 1'b0, 1'b0, 8'h12, 1'b0, 1'b0},
    {2'd0, 8'h0A, 1'b0, 1'b0, 8'h10, 1'b1, 1'b0},
    {2'd0, 8'h9A, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1},
    {2'd0, 8'h00, 1'b1, 1'b1, 8'h66, 1'b1, 1'b1},
    {2'd0, 8'hA0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1},
    {2'd0, 8'hFA, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0},
    {2'd0, 8'h9F, 1'b0, 1'b0, 8'h05, 1'b1, 1'b1},
    {2'd0, 8'h99, 1'b0, 1'b0, 8'h99, 1'b0, 1'b0},
    {2'd1, 8'h0F, 1'b0, 1'b0, 8'h09, 1'b1, 1'b0},
    {2'd1, 8'hFF, 1'b0, 1'b0, 8'h99, 1'b1, 1'b1},
    {2'd1, 8'h05, 1'b1, 1'b0, 8'h9F, 1'b1, 1'b1},
    {2'd1, 8'h45, 1'b0, 1'b1, 8'hE5, 1'b0, 1'b1},
    {2'd1, 8'h33, 1'b0, 1'b0, 8'h33, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] o, input logic [7:0] b, input logic [15:0] w,
                      input logic a, input logic c);
    @(negedge clk);
    op = o; byte_in = b; word_in = w; af_in = a; cf_in = c;
    in_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9", "valid in reset", 32'(out_valid), 0);
    check(in_ready == 1'b1, "R9", "ready in reset", 32'(in_ready), 1);
    check(byte_out == 8'h00, "R9", "byte in reset", 32'(byte_out), 0);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5 table walk
    for (int i = 0; i < NV; i++) begin
      logic [7:0] eb;
      eb = VEC[i][9:2];
      send(VEC[i][21:20], VEC[i][19:12], 16'h1234, VEC[i][11], VEC[i][10]);
      check(out_valid == 1'b1, "R8", "valid after accept", 32'(out_valid), 1);
      check(byte_out == eb, (VEC[i][21:20] == 2'd0) ? "R1/R2" : "R3", "byte",
            32'(byte_out), 32'(eb));
      check(af_out == VEC[i][1], "R1", "af", 32'(af_out), 32'(VEC[i][1]));
      check(cf_out == VEC[i][0], "R2", "cf", 32'(cf_out), 32'(VEC[i][0]));
      check(pf_out == ~^eb, "R4", "pf", 32'(pf_out), 32'(~^eb));
      check(sf_out == eb[7], "R4", "sf", 32'(sf_out), 32'(eb[7]));
      check(zf_out == (eb == 8'h00), "R4", "zf", 32'(zf_out), 32'(eb == 8'h00));
      check(we_out == 9'h01F, "R5", "write mask", 32'(we_out), 32'h1F);
      check(ofu_out == 1'b1, "R5", "of undefined", 32'(ofu_out), 1);
    end

    // R6 sign extend around the boundary
    send(2'd2, 8'h11, 16'h7FFF, 1'b1, 1'b1);
    check(ext_out == 16'h0000, "R6", "ext 7FFF", 32'(ext_out), 0);
    check(we_out == 9'h000, "R6", "no flag write", 32'(we_out), 0);
    check(ofu_out == 1'b0, "R6", "of not flagged", 32'(ofu_out), 0);
    send(2'd2, 8'h11, 16'h8000, 1'b0, 1'b0);
    check(ext_out == 16'hFFFF, "R6", "ext 8000", 32'(ext_out), 32'hFFFF);
    send(2'd2, 8'h11, 16'h0000, 1'b0, 1'b0);
    check(ext_out == 16'h0000, "R6", "ext 0000", 32'(ext_out), 0);
    send(2'd2, 8'h11, 16'hFFFF, 1'b0, 1'b0);
    check(ext_out == 16'hFFFF, "R6", "ext FFFF", 32'(ext_out), 32'hFFFF);

    // R7 reserved op
    send(2'd3, 8'h5A, 16'h8000, 1'b1, 1'b1);
    check(byte_out == 8'h5A, "R7", "byte pass", 32'(byte_out), 32'h5A);
    check(we_out == 9'h000, "R7", "no flag write", 32'(we_out), 0);
    check(ofu_out == 1'b0, "R7", "of not flagged", 32'(ofu_out), 0);
    check(ext_out == 16'h0000, "R7", "ext zero", 32'(ext_out), 0);

    // R8 backpressure
    @(negedge clk);
    op = 2'd0; byte_in = 8'h0A; af_in = 1'b0; cf_in = 1'b0;
    in_valid = 1'b1; out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    op = 2'd1; byte_in = 8'h33;
    check(out_valid == 1'b1, "R8", "valid held", 32'(out_valid), 1);
    check(in_ready == 1'b0, "R8", "ready low when stalled", 32'(in_ready), 0);
    @(posedge clk);
    @(negedge clk);
    check(byte_out == 8'h10, "R8", "byte held", 32'(byte_out), 32'h10);
    check(we_out == 9'h01F, "R8", "mask held", 32'(we_out), 32'h1F);
    out_ready = 1'b1;
    #1;
    check(in_ready == 1'b1, "R8", "ready with consumer", 32'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(byte_out == 8'h33, "R8", "second op taken", 32'(byte_out), 32'h33);
    check(out_valid == 1'b1, "R8", "valid back to back", 32'(out_valid), 1);
    @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R8", "valid drops", 32'(out_valid), 0);

    // R9 reset during a held result
    send(2'd0, 8'h0A, 16'h0, 1'b0, 1'b0);
    rst_n = 1'b0;
    #1;
    check(out_valid == 1'b0, "R9", "valid cleared", 32'(out_valid), 0);
    check(byte_out == 8'h00, "R9", "byte cleared", 32'(byte_out), 0);
    rst_n = 1'b1;

    done = 1'b1;
    finish_run();
  end
endmodule